// File: doc/BRIEF.md
# Streaming Header Field Extractor

This block lifts one protocol header out of a wide streaming data bus. The header starts at bit 0 of the word flagged as its first word and may span several bus words. Each accepted word is moved into its place in a wide header vector, and an OR accumulator collects the pieces. The first word lands in the most significant slot, and each later word sits one bus width further down. The shift for each word index is a constant that is fixed at elaboration, and the word counter picks among these constants, so no shift amount is computed at run time.

The header size is either a constant (fixed-size mode) or, in variable-size mode, it is looked up from a length field carried in the first word. A precomputed table indexed by that field gives the size in bits, the number of bus words and the mask for the partly filled last word. A length value with no valid entry, such as a value below the minimum, ends the header at once with an error flag. When the header completes, the block emits a one-cycle done pulse together with a parsed-header record. The record holds the masked header bits, the bit and word counts, a valid flag, an error flag, a constant header identifier and the packet identifier. Words are looked at only while the stage-active input and the word-valid input are both high.

Top module: `hdr_extract`

## Requirements
- R1: After reset, out_done, out_valid and out_err are 0, and out_data, out_bits and out_words are 0.
- R2: In fixed-size mode (VAR_SIZE=0) a header of FIX_BITS bits takes ceil(FIX_BITS/BUS_W) words. The first word fills out_data[HDR_W-1 -: BUS_W] and word k fills the slot BUS_W*k bits below that. out_done pulses in the cycle after the clock edge that accepts the last word, and out_done stays 0 after the earlier words.
- R3: In variable-size mode (VAR_SIZE=1) the length field is in_data[LEN_LSB +: LEN_W] of the first word (by default bits 59:56). The header size is length*LEN_UNIT bits (by default 32), and the header spans ceil(size/BUS_W) words. On completion out_bits equals the size, out_words equals the word count and out_valid is 1.
- R4: On a valid completion, every bit of out_data below the top out_bits bits is 0. This covers the tail of a partly filled last word and every unused slot.
- R5: A length value below LEN_MIN (by default 5), or one whose size exceeds HDR_W, ends the header on its first word. In that case out_done=1, out_err=1, out_valid=0, and out_bits, out_words and out_data are all 0.
- R6: A word is ignored whenever hdr_active or in_valid is low, even if in_sop is high. A header in progress resumes with the next accepted word and gives the same result as it would without the gap.
- R7: On completion out_hdr_id equals the HDR_ID parameter and out_pkt_id equals in_pkt_id as sampled on the first word. All record outputs hold their values until the next completion.
- R8: An accepted word with in_sop high always starts a new header. It clears the accumulated data and abandons any header still in progress, so no bits of the abandoned header appear in the result.
- R9: While no header is in progress, accepted words with in_sop low are ignored: out_done stays 0 and the record holds its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_active | input | 1 | Stage active: this header is to be extracted |
| in_valid | input | 1 | Bus word valid |
| in_sop | input | 1 | Word is the first word of the header |
| in_data | input | BUS_W | Bus word, header bits MSB first |
| in_pkt_id | input | PID_W | Packet identifier, sampled on the first word |
| out_done | output | 1 | One-cycle pulse when a header ends |
| out_valid | output | 1 | Record holds a correctly sized header |
| out_err | output | 1 | Length field had no valid table entry |
| out_data | output | BUS_W*MAX_WORDS | Extracted header, MSB aligned, tail masked |
| out_bits | output | 16 | Number of header bits extracted |
| out_words | output | 8 | Number of bus words the header spanned |
| out_hdr_id | output | HID_W | Header identifier (constant HDR_ID) |
| out_pkt_id | output | PID_W | Packet identifier of the extracted header |

## Verification
Every value of the 4-bit length field is swept. This covers the error values below the minimum and the sizes that end exactly on a word boundary or halfway through a word, which separates correct slot placement from correct last-word masking. A trailing payload word after each header, with its own bits set, shows whether the block stops at the header boundary. Streams with inactive and invalid gaps (some of them with in_sop high) separate real gating from counting of raw cycles. A start word that arrives mid-header checks that the accumulator is cleared. A fixed-size instance with a 112-bit header checks the constant-size path together with a partly filled second word.

// File: rtl/hx_pkg.sv
package hx_pkg;

    localparam int HX_BITS_W  = 16;
    localparam int HX_WORDS_W = 8;
    localparam int HX_MAX_BUS = 1024;

    typedef struct packed {
        logic                  ok;
        logic [HX_BITS_W-1:0]  bits;
        logic [HX_WORDS_W-1:0] words;
    } hx_size_t;

    typedef enum logic [1:0] {
        HX_SKIP  = 2'd0,
        HX_FIRST = 2'd1,
        HX_NEXT  = 2'd2
    } hx_act_e;

    // Size entry for a length value counted in units of unit_bits.
    function automatic hx_size_t hx_len_entry(int len, int unit_bits, int min_len,
                                              int bus_w, int hdr_w);
        hx_size_t e;
        int b;
        int w;
        e = '0;
        b = len * unit_bits;
        if (len >= min_len && b > 0 && b <= hdr_w) begin
            w       = (b + bus_w - 1) / bus_w;
            e.ok    = 1'b1;
            e.bits  = HX_BITS_W'(b);
            e.words = HX_WORDS_W'(w);
        end
        return e;
    endfunction

    // Mask with the top n bits of a w-bit word set.
    function automatic logic [HX_MAX_BUS-1:0] hx_top_mask(int n, int w);
        logic [HX_MAX_BUS-1:0] m;
        for (int i = 0; i < HX_MAX_BUS; i++) begin
            m[i] = (i < w) && (i >= w - n);
        end
        return m;
    endfunction

    // Constant left shift that places word k into the header vector.
    function automatic int hx_shift(int k, int bus_w, int hdr_w);
        return hdr_w - (k + 1) * bus_w;
    endfunction

endpackage

// File: rtl/hx_size_sel.sv
module hx_size_sel #(
    parameter bit VAR_SIZE = 1'b1,
    parameter int BUS_W    = 64,
    parameter int HDR_W    = 512,
    parameter int LEN_LSB  = 56,
    parameter int LEN_W    = 4,
    parameter int LEN_UNIT = 32,
    parameter int LEN_MIN  = 5,
    parameter int FIX_BITS = 112
) (
    input  logic [BUS_W-1:0] first_word,
    output hx_pkg::hx_size_t size,
    output logic [BUS_W-1:0] last_mask
);
    logic unused_fw;
    assign unused_fw = ^first_word;

    if (VAR_SIZE) begin : g_var
        localparam int ROM_N = 1 << LEN_W;
        hx_pkg::hx_size_t rom  [ROM_N];
        logic [BUS_W-1:0] mrom [ROM_N];
        logic [LEN_W-1:0] len;

        for (genvar v = 0; v < ROM_N; v++) begin : g_ent
            localparam hx_pkg::hx_size_t E =
                hx_pkg::hx_len_entry(v, LEN_UNIT, LEN_MIN, BUS_W, HDR_W);
            localparam int LAST_B =
                E.ok ? (int'(E.bits) - (int'(E.words) - 1) * BUS_W) : 0;
            localparam logic [hx_pkg::HX_MAX_BUS-1:0] M =
                hx_pkg::hx_top_mask(LAST_B, BUS_W);
            assign rom[v]  = E;
            assign mrom[v] = M[BUS_W-1:0];
        end

        assign len       = first_word[LEN_LSB +: LEN_W];
        assign size      = rom[len];
        assign last_mask = mrom[len];
    end else begin : g_fix
        localparam hx_pkg::hx_size_t E =
            hx_pkg::hx_len_entry(1, FIX_BITS, 1, BUS_W, HDR_W);
        localparam int LAST_B =
            E.ok ? (int'(E.bits) - (int'(E.words) - 1) * BUS_W) : 0;
        localparam logic [hx_pkg::HX_MAX_BUS-1:0] M =
            hx_pkg::hx_top_mask(LAST_B, BUS_W);
        assign size      = E;
        assign last_mask = M[BUS_W-1:0];
    end

endmodule

// File: rtl/hx_word_place.sv
module hx_word_place #(
    parameter int BUS_W     = 64,
    parameter int MAX_WORDS = 8,
    parameter int HDR_W     = BUS_W * MAX_WORDS
) (
    input  logic [BUS_W-1:0]                word,
    input  logic [BUS_W-1:0]                mask,
    input  logic                            use_mask,
    input  logic [hx_pkg::HX_WORDS_W-1:0]   idx,
    output logic [HDR_W-1:0]                placed
);
    logic [BUS_W-1:0] word_m;
    logic [HDR_W-1:0] cand [MAX_WORDS];

    // Bits past the header end are dropped before they reach the accumulator.
    assign word_m = use_mask ? (word & mask) : word;

    // One candidate per table slot, each with its own constant shift.
    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_slot
        localparam int SH = hx_pkg::hx_shift(k, BUS_W, HDR_W);
        assign cand[k] = HDR_W'(word_m) << SH;
    end

    always_comb begin
        placed = '0;
        for (int k = 0; k < MAX_WORDS; k++) begin
            if (idx == hx_pkg::HX_WORDS_W'(k)) begin
                placed = cand[k];
            end
        end
    end

endmodule

// File: rtl/hx_assemble.sv
module hx_assemble #(
    parameter int HDR_W  = 512,
    parameter int PID_W  = 8,
    parameter int HID_W  = 4,
    parameter int HDR_ID = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take,
    input  logic                          first,
    input  logic                          last,
    input  logic                          err,
    input  logic [HDR_W-1:0]              placed,
    input  logic [hx_pkg::HX_BITS_W-1:0]  size_bits,
    input  logic [hx_pkg::HX_WORDS_W-1:0] size_words,
    input  logic [PID_W-1:0]              pid,
    output logic                          out_done,
    output logic                          out_valid,
    output logic                          out_err,
    output logic [HDR_W-1:0]              out_data,
    output logic [hx_pkg::HX_BITS_W-1:0]  out_bits,
    output logic [hx_pkg::HX_WORDS_W-1:0] out_words,
    output logic [HID_W-1:0]              out_hdr_id,
    output logic [PID_W-1:0]              out_pkt_id
);
    logic [HDR_W-1:0] acc_q;
    logic [HDR_W-1:0] merged;

    // A first word replaces the accumulator; later words are ORed in.
    assign merged = first ? placed : (acc_q | placed);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            out_done   <= 1'b0;
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_data   <= '0;
            out_bits   <= '0;
            out_words  <= '0;
            out_hdr_id <= '0;
            out_pkt_id <= '0;
        end else begin
            out_done <= 1'b0;
            if (take) begin
                if (last) begin
                    acc_q      <= '0;
                    out_done   <= 1'b1;
                    out_valid  <= !err;
                    out_err    <= err;
                    out_data   <= err ? '0 : merged;
                    out_bits   <= err ? '0 : size_bits;
                    out_words  <= err ? '0 : size_words;
                    out_hdr_id <= HID_W'(HDR_ID);
                    out_pkt_id <= pid;
                end else begin
                    acc_q <= merged;
                end
            end
        end
    end

    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_err) |-> (out_bits == '0 && out_words == '0 && out_data == '0)); // R5

    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_data) && $stable(out_pkt_id) && $stable(out_bits))); // R7

endmodule

// File: rtl/hdr_extract.sv
module hdr_extract #(
    parameter bit VAR_SIZE  = 1'b1,
    parameter int BUS_W     = 64,
    parameter int MAX_WORDS = 8,
    parameter int PID_W     = 8,
    parameter int HID_W     = 4,
    parameter int HDR_ID    = 3,
    parameter int LEN_LSB   = 56,
    parameter int LEN_W     = 4,
    parameter int LEN_UNIT  = 32,
    parameter int LEN_MIN   = 5,
    parameter int FIX_BITS  = 112,
    localparam int HDR_W    = BUS_W * MAX_WORDS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hdr_active,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic [BUS_W-1:0]              in_data,
    input  logic [PID_W-1:0]              in_pkt_id,
    output logic                          out_done,
    output logic                          out_valid,
    output logic                          out_err,
    output logic [HDR_W-1:0]              out_data,
    output logic [hx_pkg::HX_BITS_W-1:0]  out_bits,
    output logic [hx_pkg::HX_WORDS_W-1:0] out_words,
    output logic [HID_W-1:0]              out_hdr_id,
    output logic [PID_W-1:0]              out_pkt_id
);
    import hx_pkg::*;

    hx_act_e               act;
    logic                  first;
    logic                  take;
    logic                  bad;
    logic                  last;
    hx_size_t              size_now;
    hx_size_t              size_q;
    hx_size_t              cur_size;
    logic [BUS_W-1:0]      mask_now;
    logic [BUS_W-1:0]      mask_q;
    logic [BUS_W-1:0]      cur_mask;
    logic [HX_WORDS_W-1:0] cnt_q;
    logic [HX_WORDS_W-1:0] idx;
    logic                  busy_q;
    logic [PID_W-1:0]      pid_q;
    logic [PID_W-1:0]      cur_pid;
    logic [HDR_W-1:0]      placed;
    logic                  unused_q;

    assign unused_q = size_q.ok;

    hx_size_sel #(
        .VAR_SIZE (VAR_SIZE),
        .BUS_W    (BUS_W),
        .HDR_W    (HDR_W),
        .LEN_LSB  (LEN_LSB),
        .LEN_W    (LEN_W),
        .LEN_UNIT (LEN_UNIT),
        .LEN_MIN  (LEN_MIN),
        .FIX_BITS (FIX_BITS)
    ) u_size (
        .first_word (in_data),
        .size       (size_now),
        .last_mask  (mask_now)
    );

    // Word classification: only gated words with a start flag or an open header count.
    always_comb begin
        act = HX_SKIP;
        if (hdr_active && in_valid) begin
            if (in_sop) begin
                act = HX_FIRST;
            end else if (busy_q) begin
                act = HX_NEXT;
            end
        end
    end

    assign first    = (act == HX_FIRST);
    assign take     = (act != HX_SKIP);
    assign cur_size = first ? size_now : size_q;
    assign cur_mask = first ? mask_now : mask_q;
    assign cur_pid  = first ? in_pkt_id : pid_q;
    assign idx      = first ? '0 : cnt_q;
    assign bad      = first && !size_now.ok;
    assign last     = take && (bad || (idx == cur_size.words - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            size_q <= '0;
            mask_q <= '0;
            pid_q  <= '0;
        end else if (take) begin
            if (first) begin
                size_q <= size_now;
                mask_q <= mask_now;
                pid_q  <= in_pkt_id;
            end
            if (last) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                busy_q <= 1'b1;
                cnt_q  <= idx + 1'b1;
            end
        end
    end

    hx_word_place #(
        .BUS_W     (BUS_W),
        .MAX_WORDS (MAX_WORDS),
        .HDR_W     (HDR_W)
    ) u_place (
        .word     (in_data),
        .mask     (cur_mask),
        .use_mask (last),
        .idx      (idx),
        .placed   (placed)
    );

    hx_assemble #(
        .HDR_W  (HDR_W),
        .PID_W  (PID_W),
        .HID_W  (HID_W),
        .HDR_ID (HDR_ID)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .first      (first),
        .last       (last),
        .err        (bad),
        .placed     (placed),
        .size_bits  (cur_size.bits),
        .size_words (cur_size.words),
        .pid        (cur_pid),
        .out_done   (out_done),
        .out_valid  (out_valid),
        .out_err    (out_err),
        .out_data   (out_data),
        .out_bits   (out_bits),
        .out_words  (out_words),
        .out_hdr_id (out_hdr_id),
        .out_pkt_id (out_pkt_id)
    );

    AST_HOLD_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        !(hdr_active && in_valid) |=> ($stable(cnt_q) && $stable(busy_q) && !out_done)); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q != '0 && cnt_q < size_q.words)); // R2

    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(hdr_active && in_valid)); // R6

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_valid) |-> ((out_data << out_bits) == '0)); // R4

endmodule

// File: tb/hdr_extract_tb.sv
module hdr_extract_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         act = 1'b0;
    logic         vld = 1'b0;
    logic         sop = 1'b0;
    logic [63:0]  data = '0;
    logic [7:0]   pid = '0;

    logic         d_done, d_valid, d_err;
    logic [511:0] d_data;
    logic [15:0]  d_bits;
    logic [7:0]   d_words;
    logic [3:0]   d_hid;
    logic [7:0]   d_pid;

    logic         f_done, f_valid, f_err;
    logic [511:0] f_data;
    logic [15:0]  f_bits;
    logic [7:0]   f_words;
    logic [3:0]   f_hid;
    logic [7:0]   f_pid;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hdr_extract u_dut (
        .clk(clk), .rst(rst), .hdr_active(act), .in_valid(vld), .in_sop(sop),
        .in_data(data), .in_pkt_id(pid),
        .out_done(d_done), .out_valid(d_valid), .out_err(d_err), .out_data(d_data),
        .out_bits(d_bits), .out_words(d_words), .out_hdr_id(d_hid), .out_pkt_id(d_pid)
    );

    hdr_extract #(.VAR_SIZE(1'b0), .FIX_BITS(112), .HDR_ID(9)) u_fix (
        .clk(clk), .rst(rst), .hdr_active(act), .in_valid(vld), .in_sop(sop),
        .in_data(data), .in_pkt_id(pid),
        .out_done(f_done), .out_valid(f_valid), .out_err(f_err), .out_data(f_data),
        .out_bits(f_bits), .out_words(f_words), .out_hdr_id(f_hid), .out_pkt_id(f_pid)
    );

    task automatic check(input string req, input string what,
                         input logic [511:0] got, input logic [511:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic a, input logic v, input logic s,
                        input logic [63:0] d, input logic [7:0] p);
        @(negedge clk);
        act = a; vld = v; sop = s; data = d; pid = p;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [63:0] wgen(int seed, int k, int len);
        logic [63:0] w;
        w = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(seed) << 12) ^ (64'(k + 1) * 64'h0101_0101_0101_0101);
        if (k == 0) w[59:56] = 4'(len);
        return w;
    endfunction

    function automatic logic [511:0] exp_data(int seed, int len, int bits, int words);
        logic [511:0] e;
        e = '0;
        for (int k = 0; k < words; k++) begin
            e |= {wgen(seed, k, len), 448'b0} >> (64 * k);
        end
        e &= ~({512{1'b1}} >> bits);
        return e;
    endfunction

    // Variable-size header: full check of the record, then one trailing payload word.
    task automatic run_var(input int len, input int seed, input logic [7:0] p);
        int bits;
        int words;
        bit ok;
        logic [511:0] e;
        bits  = len * 32;
        ok    = (len >= 5);
        words = ok ? (bits + 63) / 64 : 1;
        e     = ok ? exp_data(seed, len, bits, words) : '0;
        for (int k = 0; k < words; k++) begin
            step(1'b1, 1'b1, k == 0, wgen(seed, k, len), p);
            if (k < words - 1) check("R2", "early done", 512'(d_done), 512'(0));
        end
        check("R3", "done", 512'(d_done), 512'(1));
        if (ok) begin
            check("R3", "valid", 512'({d_valid, d_err}), 512'(2'b10));
            check("R3", "bits", 512'(d_bits), 512'(bits));
            check("R3", "words", 512'(d_words), 512'(words));
            check("R3", "data", d_data, e);
            check("R4", "tail", d_data & ({512{1'b1}} >> bits), '0);
        end else begin
            check("R5", "valid/err", 512'({d_valid, d_err}), 512'(2'b01));
            check("R5", "bits/words", 512'({d_bits, d_words}), 512'(0));
            check("R5", "data", d_data, '0);
        end
        check("R7", "pkt id", 512'(d_pid), 512'(p));
        check("R7", "hdr id", 512'(d_hid), 512'(3));
        step(1'b1, 1'b1, 1'b0, ~wgen(seed, 9, len), p + 8'd1);
        check("R9", "trailing done", 512'(d_done), 512'(0));
        check("R7", "held data", d_data, e);
        check("R7", "held pkt id", 512'(d_pid), 512'(p));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [511:0] e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "done/valid/err", 512'({d_done, d_valid, d_err}), 512'(0));
        check("R1", "data", d_data, '0);
        check("R1", "bits/words", 512'({d_bits, d_words}), 512'(0));
        check("R1", "fixed done", 512'({f_done, f_valid, f_err}), 512'(0));

        // R9: stray words with no header open
        step(1'b1, 1'b1, 1'b0, 64'hDEAD_BEEF_0000_1111, 8'h11);
        check("R9", "idle done", 512'(d_done), 512'(0));

        // R3/R4/R5: sweep of every length value, two seeds
        for (int s = 0; s < 2; s++) begin
            for (int len = 0; len < 16; len++) begin
                run_var(len, s * 20 + len, 8'(len + 16 * s));
            end
        end

        // R6: gaps inside a 7-unit header (224 bits, 4 words)
        e = exp_data(40, 7, 224, 4);
        step(1'b1, 1'b1, 1'b1, wgen(40, 0, 7), 8'h5A);
        step(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
        check("R6", "inactive done", 512'(d_done), 512'(0));
        step(1'b1, 1'b0, 1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 8'h02);
        check("R6", "invalid done", 512'(d_done), 512'(0));
        step(1'b1, 1'b1, 1'b0, wgen(40, 1, 7), 8'h03);
        step(1'b0, 1'b0, 1'b0, 64'h1234, 8'h04);
        step(1'b1, 1'b1, 1'b0, wgen(40, 2, 7), 8'h05);
        check("R6", "done before last", 512'(d_done), 512'(0));
        step(1'b1, 1'b1, 1'b0, wgen(40, 3, 7), 8'h06);
        check("R6", "done", 512'(d_done), 512'(1));
        check("R6", "data with gaps", d_data, e);
        check("R6", "pkt id with gaps", 512'(d_pid), 512'(8'h5A));

        // R8: restart mid-header
        step(1'b1, 1'b1, 1'b1, wgen(50, 0, 12), 8'h70);
        step(1'b1, 1'b1, 1'b0, wgen(50, 1, 12), 8'h70);
        step(1'b1, 1'b1, 1'b0, wgen(50, 2, 12), 8'h70);
        check("R8", "no done before restart", 512'(d_done), 512'(0));
        e = exp_data(51, 5, 160, 3);
        step(1'b1, 1'b1, 1'b1, wgen(51, 0, 5), 8'h71);
        step(1'b1, 1'b1, 1'b0, wgen(51, 1, 5), 8'h71);
        step(1'b1, 1'b1, 1'b0, wgen(51, 2, 5), 8'h71);
        check("R8", "restart done", 512'(d_done), 512'(1));
        check("R8", "restart data", d_data, e);
        check("R8", "restart pkt id", 512'(d_pid), 512'(8'h71));

        // R2: fixed 112-bit header on the second instance
        for (int s = 60; s < 64; s++) begin
            e = exp_data(s, s & 15, 112, 2);
            step(1'b1, 1'b1, 1'b1, wgen(s, 0, s & 15), 8'(s));
            check("R2", "fixed early done", 512'(f_done), 512'(0));
            if (s == 62) begin
                step(1'b1, 1'b0, 1'b0, 64'hAAAA, 8'h00);
                check("R6", "fixed gap done", 512'(f_done), 512'(0));
            end
            step(1'b1, 1'b1, 1'b0, wgen(s, 1, s & 15), 8'(s));
            check("R2", "fixed done", 512'({f_done, f_valid, f_err}), 512'(3'b110));
            check("R2", "fixed bits/words", 512'({f_bits, f_words}), 512'({16'd112, 8'd2}));
            check("R2", "fixed data", f_data, e);
            check("R4", "fixed tail", f_data & ({512{1'b1}} >> 112), '0);
            check("R7", "fixed ids", 512'({f_hid, f_pid}), 512'({4'd9, 8'(s)}));
            step(1'b0, 1'b0, 1'b0, 64'h0, 8'h00);
        end

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule